// File: doc/BRIEF.md
# Mode-Switched Multiply-Accumulate Unit

This block multiplies two unsigned 32-bit operands into a 64-bit result and can sum successive products into a 64-bit accumulator. Software and the surrounding datapath reach it through a small word window: a control/status word, the product as two 32-bit halves and the accumulator as two 32-bit halves. The two operand buses come straight in from the datapath.

In multiply-only mode the operands are taken on every clock and the product follows them with one register of latency, while the accumulator stays at zero. In accumulate mode the operands are taken only when a transfer touches the control word. That transfer adds their product to the accumulator and loads the new sum into both the product and the accumulator. A 64-bit wrap raises a sticky carry flag. Writing a one to that flag clears it and empties the accumulator.

Transfers are byte-granular. A transfer names a start word, a start byte lane and a byte count. Its bytes fill successive lanes and continue into the next word after the top lane. Only the first three words (control and product) may be the target of a transfer, and one that reaches past them is dropped and flagged.

Top module: `mac_window_unit`

## Requirements
- R1: While reset is asserted and after its release, all five window words read 0, the mode is multiply-only and `xfer_err` is 0.
- R2: With mode bit 0, each rising clock edge loads the product with the unsigned 64-bit product of the `op_a` and `op_b` values present at that edge. Product low half is window word 1 and high half is word 2.
- R3: With mode bit 0, the accumulator (word 3 low, word 4 high) is held at zero.
- R4: With mode bit 1 and no transfer touching word 0, the product and accumulator keep their values whatever the operand inputs do.
- R5: A transfer that touches word 0, leaves mode bit (bit 0 of word 0) at 1 and does not request a clear loads both the product and the accumulator with (accumulator + op_a*op_b) mod 2^64, using the operands present at that edge.
- R6: When the sum of R5 is numerically smaller than the old accumulator, carry (bit 1 of word 0) becomes 1. It stays 1 through later transfers that do not clear it.
- R7: A transfer that writes lane 0 of word 0 with bit 1 set clears carry and zeroes the accumulator, performs no accumulation, leaves the product unchanged in accumulate mode, and takes the mode from bit 0 of the same byte.
- R8: Byte k of `wr_data` (bits 8k+7..8k) lands at flat byte position 4*`wr_word` + `wr_lane` + k, where flat position p is lane p mod 4 of word p/4. Only bits 0 and 1 of word 0 are stored, and all other bits of word 0 read 0.
- R9: Bytes landing in words 1 and 2 are discarded. A transfer that does not touch word 0 changes no window word.
- R10: A transfer with nonzero length and 4*`wr_word` + `wr_lane` + `wr_len` > 12 has no effect, and `xfer_err` is 1 in exactly the following cycle. Any other transfer gives `xfer_err` 0.
- R11: `rd_data` shows the word chosen by `rd_word` combinationally, and indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| wr_en | input | 1 | Transfer strobe, one transfer per cycle |
| wr_word | input | 3 | Start word of the transfer |
| wr_lane | input | 2 | Start byte lane within the start word |
| wr_len | input | 4 | Number of bytes in the transfer, 0 to 15 |
| wr_data | input | 96 | Transfer bytes, byte k at bits 8k+7..8k |
| rd_word | input | 3 | Window word to show on rd_data |
| rd_data | output | 32 | Selected window word |
| xfer_err | output | 1 | Out-of-range transfer flag for the previous cycle |

## Verification
Multiply-only mode is driven with walking-one operands against an all-ones partner, with all-ones on both sides for the largest product, with zero, and with a long pseudo-random sequence. Together these separate a correct full 64-bit product from a truncated one, from one with swapped halves, and from one that lags by a cycle. Accumulate mode is run with small operands for exact sums. It is then run with all-ones operands until the accumulator wraps, which separates a sticky carry from a momentary one and a clear request from a plain control write. A sweep over every start word, lane and length in multiply-only mode compares `xfer_err` against the range rule, with the boundary lengths that end exactly at byte 12 and one past it.

// File: rtl/mac_win_pkg.sv
package mac_win_pkg;

   // Bit positions inside the control/status word.
   localparam int CTRL_MODE_BIT  = 0;
   localparam int CTRL_CARRY_BIT = 1;

   // Index of each word in the register window.
   typedef enum logic [2:0] {
      WIN_CTRL    = 3'd0,
      WIN_PROD_LO = 3'd1,
      WIN_PROD_HI = 3'd2,
      WIN_ACC_LO  = 3'd3,
      WIN_ACC_HI  = 3'd4
   } win_idx_e;

   // What a transfer does to the control word in the current cycle.
   typedef struct packed {
      logic touch;    // at least one byte lands in the control word
      logic lane0;    // the lowest byte of the control word is written
      logic mode_val; // mode bit carried by that byte
      logic clr_val;  // clear request carried by that byte
   } ctrl_req_t;

endpackage

// File: rtl/mac_win_decode.sv
module mac_win_decode
   import mac_win_pkg::*;
#(
   parameter int OP_W       = 32,
   parameter int XFER_WORDS = 3,
   parameter int LEN_W      = 4,
   parameter int WSEL_W     = 3,
   localparam int LANES     = OP_W / 8,
   localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [WSEL_W-1:0]          wr_word,
   input  logic [LANE_W-1:0]          wr_lane,
   input  logic [LEN_W-1:0]           wr_len,
   input  logic [OP_W*XFER_WORDS-1:0] wr_data,
   output ctrl_req_t                  req,
   output logic                       err_q
);

   localparam int LIMIT = XFER_WORDS * LANES;
   localparam int SUM_W = WSEL_W + LANE_W + LEN_W + 2;

   logic [SUM_W-1:0] start_pos;
   logic [SUM_W-1:0] end_pos;
   logic             over;
   logic             go;
   logic [LANES-1:0] lane_hit;
   logic             unused_bytes;

   assign start_pos = SUM_W'(wr_word) * SUM_W'(LANES) + SUM_W'(wr_lane);
   assign end_pos   = start_pos + SUM_W'(wr_len);
   assign over      = (wr_len != '0) && (end_pos > SUM_W'(LIMIT));
   assign go        = wr_en && (wr_len != '0) && !over;

   // One hit per control-word lane: the lane lies inside [start, end).
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_hit[j] = go && (start_pos <= SUM_W'(j)) && (end_pos > SUM_W'(j));
   end

   // Lane 0 can only be reached by the first byte of a transfer.
   assign req.touch    = |lane_hit;
   assign req.lane0    = lane_hit[0];
   assign req.mode_val = wr_data[CTRL_MODE_BIT];
   assign req.clr_val  = wr_data[CTRL_CARRY_BIT];

   // Bytes bound for read-only words are dropped.
   assign unused_bytes = ^wr_data[OP_W*XFER_WORDS-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en && over;
   end

endmodule

// File: rtl/mac_acc_core.sv
module mac_acc_core
   import mac_win_pkg::*;
#(
   parameter int OP_W = 32,
   localparam int PW  = 2 * OP_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] op_a,
   input  logic [OP_W-1:0] op_b,
   input  ctrl_req_t       req,
   output logic            mode_q,
   output logic            carry_q,
   output logic [PW-1:0]   prod_q,
   output logic [PW-1:0]   acc_q
);

   logic [PW-1:0] mul;
   logic [PW-1:0] sum;
   logic          wrap;
   logic          new_mode;
   logic          clr;
   logic          acc_op;

   assign mul      = PW'(op_a) * PW'(op_b);
   assign sum      = acc_q + mul;
   assign wrap     = sum < acc_q;
   assign new_mode = req.lane0 ? req.mode_val : mode_q;
   assign clr      = req.lane0 && req.clr_val;
   assign acc_op   = req.touch && new_mode && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         carry_q <= 1'b0;
         prod_q  <= '0;
         acc_q   <= '0;
      end else begin
         mode_q <= new_mode;
         if (clr)
            carry_q <= 1'b0;
         else if (acc_op && wrap)
            carry_q <= 1'b1;

         if (acc_op) begin
            prod_q <= sum;
            acc_q  <= sum;
         end else if (!mode_q) begin
            prod_q <= mul;
            acc_q  <= '0;
         end else if (clr) begin
            acc_q  <= '0;
         end
      end
   end

   // R2: multiply-only mode tracks the operands of the previous edge
   p_mul_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !acc_op) |=> (prod_q == PW'($past(op_a)) * PW'($past(op_b))));

   // R3: accumulator empty in multiply-only mode
   p_acc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !acc_op) |=> (acc_q == '0));

   // R4: accumulate mode holds without a control-word transfer
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !req.touch) |=> ($stable(prod_q) && $stable(acc_q)));

   // R6: carry is sticky until cleared
   p_carry_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_q && !clr) |=> carry_q);

   // R7: clear empties carry and accumulator
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!carry_q && acc_q == '0));

endmodule

// File: rtl/mac_read_mux.sv
module mac_read_mux
   import mac_win_pkg::*;
#(
   parameter int OP_W   = 32,
   parameter int WSEL_W = 3,
   localparam int PW    = 2 * OP_W
) (
   input  logic [WSEL_W-1:0] rd_word,
   input  logic              mode_q,
   input  logic              carry_q,
   input  logic [PW-1:0]     prod_q,
   input  logic [PW-1:0]     acc_q,
   output logic [OP_W-1:0]   rd_data
);

   logic [OP_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word                 = '0;
      ctrl_word[CTRL_MODE_BIT]  = mode_q;
      ctrl_word[CTRL_CARRY_BIT] = carry_q;
   end

   always_comb begin
      case (rd_word)
         WSEL_W'(WIN_CTRL):    rd_data = ctrl_word;
         WSEL_W'(WIN_PROD_LO): rd_data = prod_q[OP_W-1:0];
         WSEL_W'(WIN_PROD_HI): rd_data = prod_q[PW-1:OP_W];
         WSEL_W'(WIN_ACC_LO):  rd_data = acc_q[OP_W-1:0];
         WSEL_W'(WIN_ACC_HI):  rd_data = acc_q[PW-1:OP_W];
         default:              rd_data = '0;
      endcase
   end

endmodule

// File: rtl/mac_window_unit.sv
module mac_window_unit
   import mac_win_pkg::*;
#(
   parameter int OP_W       = 32,
   parameter int XFER_WORDS = 3,
   parameter int LEN_W      = 4,
   parameter int WSEL_W     = 3,
   localparam int LANES     = OP_W / 8,
   localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int PW        = 2 * OP_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [OP_W-1:0]            op_a,
   input  logic [OP_W-1:0]            op_b,
   input  logic                       wr_en,
   input  logic [WSEL_W-1:0]          wr_word,
   input  logic [LANE_W-1:0]          wr_lane,
   input  logic [LEN_W-1:0]           wr_len,
   input  logic [OP_W*XFER_WORDS-1:0] wr_data,
   input  logic [WSEL_W-1:0]          rd_word,
   output logic [OP_W-1:0]            rd_data,
   output logic                       xfer_err
);

   if (OP_W % 8 != 0 || OP_W < 16) begin : g_bad_op_w
      $error("mac_window_unit: OP_W must be a multiple of 8 and at least 16");
   end
   if (XFER_WORDS < 1 || XFER_WORDS > 3) begin : g_bad_xfer
      $error("mac_window_unit: XFER_WORDS must be 1..3 (control and product words)");
   end
   if (WSEL_W < 3) begin : g_bad_wsel
      $error("mac_window_unit: WSEL_W must address five window words");
   end

   ctrl_req_t     req;
   logic          mode_q;
   logic          carry_q;
   logic [PW-1:0] prod_q;
   logic [PW-1:0] acc_q;

   mac_win_decode #(
      .OP_W(OP_W), .XFER_WORDS(XFER_WORDS), .LEN_W(LEN_W), .WSEL_W(WSEL_W)
   ) i_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .wr_lane(wr_lane), .wr_len(wr_len), .wr_data(wr_data),
      .req(req), .err_q(xfer_err)
   );

   mac_acc_core #(.OP_W(OP_W)) i_core (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .req(req),
      .mode_q(mode_q), .carry_q(carry_q), .prod_q(prod_q), .acc_q(acc_q)
   );

   mac_read_mux #(.OP_W(OP_W), .WSEL_W(WSEL_W)) i_rmux (
      .rd_word(rd_word), .mode_q(mode_q), .carry_q(carry_q),
      .prod_q(prod_q), .acc_q(acc_q), .rd_data(rd_data)
   );

endmodule

// File: tb/test_mac_window_unit.sv
module test_mac_window_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_word = '0;
   logic [1:0]  wr_lane = '0;
   logic [3:0]  wr_len = '0;
   logic [95:0] wr_data = '0;
   logic [2:0]  rd_word = '0;
   logic [31:0] rd_data;
   logic        xfer_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   mac_window_unit i_mac_window_unit (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .wr_en(wr_en),
      .wr_word(wr_word), .wr_lane(wr_lane), .wr_len(wr_len), .wr_data(wr_data),
      .rd_word(rd_word), .rd_data(rd_data), .xfer_err(xfer_err)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int idx, output logic [31:0] v);
      rd_word = idx[2:0];
      #1;
      v = rd_data;
   endtask

   task automatic rd64(input int lo_idx, output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(lo_idx, lo);
      rd(lo_idx + 1, hi);
      v = {hi, lo};
   endtask

   // Called at a falling edge; returns at the falling edge after the transfer edge.
   task automatic xfer(input int w, input int l, input int n, input logic [95:0] d);
      wr_word = w[2:0];
      wr_lane = l[1:0];
      wr_len  = n[3:0];
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [63:0] p, a, exp_acc, exp_prod, prev, mul;
      logic [31:0] lcg;
      logic        carry_exp;
      logic        exp_err;

      // ---------------- R1: reset state ----------------
      repeat (3) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         rd(i, v);
         check($sformatf("R1 word %0d during reset", i), 64'(v), 64'h0);
      end
      check("R1 xfer_err during reset", 64'(xfer_err), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(0, v);
      check("R1 mode after release", 64'(v), 64'h0);
      rd64(3, a);
      check("R1 accumulator after release", a, 64'h0);

      // ---------------- R2 / R3: multiply-only sweep ----------------
      lcg = 32'h1234_5679;
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ta, tb;
         if (i < 32)       begin ta = 32'h1 << i; tb = 32'hFFFF_FFFF; end
         else if (i < 36)  begin ta = 32'hFFFF_FFFF; tb = 32'hFFFF_FFFF; end
         else if (i < 38)  begin ta = 32'h0; tb = 32'hDEAD_BEEF; end
         else begin
            lcg = lcg * 32'd1664525 + 32'd1013904223; ta = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; tb = lcg;
         end
         op_a = ta;
         op_b = tb;
         @(negedge clk);
         rd64(1, p);
         check($sformatf("R2 product a=%h b=%h", ta, tb), p, 64'(ta) * 64'(tb));
         if (i % 25 == 0) begin
            rd64(3, a);
            check("R3 accumulator zero in multiply-only", a, 64'h0);
         end
      end

      // ---------------- R5 / R8: enter accumulate mode ----------------
      op_a = 32'd3;
      op_b = 32'd5;
      // byte0 = 0x01 (mode 1); bytes 1..3 all ones must not be stored
      xfer(0, 0, 4, 96'h0000_0000_0000_0000_FFFF_FF01);
      exp_acc = 64'd15;
      rd(0, v);
      check("R8 control word reserved bits read zero", 64'(v), 64'h1);
      rd64(3, a);
      check("R5 first accumulation", a, exp_acc);
      rd64(1, p);
      check("R5 product equals sum", p, exp_acc);

      // ---------------- R4: hold without control transfer ----------------
      for (int i = 0; i < 6; i++) begin
         op_a = 32'hA5A5_0000 + 32'(i);
         op_b = 32'h0F0F_1234 ^ 32'(i * 7);
         @(negedge clk);
      end
      rd64(1, p);
      check("R4 product held in accumulate mode", p, 64'd15);
      rd64(3, a);
      check("R4 accumulator held in accumulate mode", a, 64'd15);

      // ---------------- R5: several accumulations ----------------
      for (int i = 0; i < 8; i++) begin
         op_a = 32'd1000 + 32'(i * 37);
         op_b = 32'd77 + 32'(i);
         xfer(0, 0, 1, 96'h01);
         exp_acc = exp_acc + 64'(op_a) * 64'(op_b);
         rd64(3, a);
         check($sformatf("R5 accumulation step %0d", i), a, exp_acc);
      end
      // R8: byte 0 goes to lane 1, so 0x03 neither clears nor changes mode
      op_a = 32'd11;
      op_b = 32'd13;
      xfer(0, 1, 1, 96'h03);
      exp_acc = exp_acc + 64'd143;
      rd(0, v);
      check("R8 lane-1 byte leaves control bits", 64'(v), 64'h1);
      rd64(3, a);
      check("R8 lane-1 transfer still accumulates", a, exp_acc);

      // ---------------- R6: wrap sets sticky carry ----------------
      op_a = 32'hFFFF_FFFF;
      op_b = 32'hFFFF_FFFF;
      mul  = 64'(op_a) * 64'(op_b);
      carry_exp = 1'b0;
      for (int i = 0; i < 3; i++) begin
         xfer(0, 0, 1, 96'h01);
         prev    = exp_acc;
         exp_acc = exp_acc + mul;
         if (exp_acc < prev) carry_exp = 1'b1;
      end
      rd(0, v);
      check("R6 carry after wrap", 64'(v), {62'h0, carry_exp, 1'b1});
      rd64(3, a);
      check("R6 accumulator after wrap", a, exp_acc);
      op_a = 32'd2;
      op_b = 32'd2;
      xfer(0, 0, 1, 96'h01);
      exp_acc = exp_acc + 64'd4;
      rd(0, v);
      check("R6 carry sticky through plain write", 64'(v), 64'h3);
      exp_prod = exp_acc;

      // ---------------- R7: clear request ----------------
      op_a = 32'd9;
      op_b = 32'd9;
      xfer(0, 0, 1, 96'h03);
      rd(0, v);
      check("R7 carry cleared, mode kept", 64'(v), 64'h1);
      rd64(3, a);
      check("R7 accumulator zeroed", a, 64'h0);
      rd64(1, p);
      check("R7 product unchanged by clear", p, exp_prod);
      op_a = 32'd6;
      op_b = 32'd7;
      xfer(0, 0, 1, 96'h01);
      rd64(3, a);
      check("R7 accumulation restarts from zero", a, 64'd42);
      exp_acc = 64'd42;

      // ---------------- R9: read-only words ----------------
      xfer(1, 0, 8, {32'h0, 64'hABAB_ABAB_ABAB_ABAB});
      rd64(1, p);
      check("R9 product not writable", p, 64'd42);
      rd64(3, a);
      check("R9 no accumulation without control access", a, 64'd42);
      check("R9 legal transfer no error", 64'(xfer_err), 64'h0);
      xfer(1, 2, 6, 96'hFFFF_FFFF_FFFF);
      rd64(1, p);
      check("R9 transfer ending at limit ignored", p, 64'd42);

      // ---------------- R10: out-of-range transfer dropped ----------------
      xfer(0, 0, 13, 96'h0);
      check("R10 error flagged", 64'(xfer_err), 64'h1);
      rd(0, v);
      check("R10 mode untouched by dropped transfer", 64'(v), 64'h1);
      rd64(3, a);
      check("R10 no accumulation from dropped transfer", a, 64'd42);
      @(negedge clk);
      check("R10 error is one cycle", 64'(xfer_err), 64'h0);

      // ---------------- back to multiply-only ----------------
      xfer(0, 0, 1, 96'h00);
      rd(0, v);
      check("R3 mode cleared", 64'(v), 64'h0);
      op_a = 32'h0001_0000;
      op_b = 32'h0001_0000;
      @(negedge clk);
      rd64(3, a);
      check("R3 accumulator zero after leaving accumulate", a, 64'h0);
      rd64(1, p);
      check("R2 product resumes tracking", p, 64'h1_0000_0000);

      // ---------------- R10: exhaustive decode sweep ----------------
      for (int w = 0; w < 8; w++) begin
         for (int l = 0; l < 4; l++) begin
            for (int n = 0; n < 16; n++) begin
               exp_err = (n != 0) && (w * 4 + l + n > 12);
               xfer(w, l, n, 96'h0);
               check($sformatf("R10 err w=%0d l=%0d n=%0d", w, l, n),
                     64'(xfer_err), 64'(exp_err));
            end
         end
      end
      xfer(0, 0, 13, 96'h01);
      rd(0, v);
      check("R10 dropped transfer cannot set mode", 64'(v), 64'h0);

      // ---------------- R11: unmapped read indices ----------------
      for (int i = 5; i < 8; i++) begin
         rd(i, v);
         check($sformatf("R11 index %0d reads zero", i), 64'(v), 64'h0);
      end

      done = 1'b1;
      finish_run();
   end

endmodule